// File: doc/BRIEF.md
# Split-Frame Serial Downstream Transmitter

This block sends 32-bit frames to external devices over a synchronous serial link. It provides its own serial clock and shifts the frame out least significant bit first. The frame register has a low half and a high half of 16 bits each. When a data frame starts, every bit of the register picks its own source through a 2-bit code. The source is the data word, the command word, or the matching bit of a 16-bit alternate parallel bus: the low bus feeds the low half and the high bus feeds the high half. A command frame sends the whole command word.

While a frame is being shifted, three phase strobes are produced: low half, high half and command. A small mapping stage routes them onto four enable outputs, and each output has its own selection and polarity. The serial clock and the serial data are each driven in true and complement form. An emergency-stop input aborts a running frame at once and holds the link quiet. When a frame finishes normally, the block raises a single-cycle completion pulse.

Top module: `sdt_tx`

## Requirements
- R1: After reset, `sclk_p` is 0, `sdo_p` equals `safe_lvl`, each `en_out[i]` equals `en_pol[i]`, and both `busy` and `frame_done` are 0.
- R2: A data frame (`start`=1 with `cmd_frame`=0 while idle) loads bit i from `src_sel[2i+1:2i]`. Code 00 selects `data_word[i]`, 01 selects `cmd_word[i]`, 10 selects `alt_lo[i]` for i<16 or `alt_hi[i-16]` for i>=16, and 11 behaves as 00.
- R3: A command frame (`start`=1 with `cmd_frame`=1 while idle) transmits `cmd_word` unchanged.
- R4: Bits go out LSB first, with the half period of the serial clock equal to `div`+1 module clocks. Each bit is presented while `sclk_p` is low for one half period, then stays stable while `sclk_p` is high for the next half period. The data changes only when `sclk_p` falls. `sclk_p` stays 0 when no frame is running.
- R5: The low phase is active during bits 0 to 15 of a data frame and the high phase during bits 16 to 31. The command phase is active throughout a command frame.
- R6: Each `en_out[i]` equals the phase picked by `en_sel[3i+2:3i]`, XORed with `en_pol[i]`. The codes are 0 = low, 1 = high, 2 = command, 3 = low OR high, and any other code = never active.
- R7: `sclk_n` is always the inverse of `sclk_p`, and `sdo_n` is always the inverse of `sdo_p`.
- R8: While `estop` is 1, `sdo_p` equals `safe_lvl`, `sclk_p` is 0 and every enable is inactive, all in the same cycle. A running frame is dropped at the next clock edge and gives no `frame_done`.
- R9: `start` has no effect while `estop` is 1. It also has no effect while a frame is in progress: the running frame's bits do not change, even if the data inputs change.
- R10: `frame_done` is high for exactly one cycle. That cycle starts at the clock edge of the last falling edge of `sclk_p`, and all enables are inactive during it.
- R11: `busy` rises one clock after an accepted start and falls one clock after the `frame_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a frame |
| cmd_frame | input | 1 | Frame type given with start: 1 = command frame |
| data_word | input | 32 | Data word source |
| cmd_word | input | 32 | Command word source |
| alt_lo | input | 16 | Alternate bus for the low half |
| alt_hi | input | 16 | Alternate bus for the high half |
| src_sel | input | 64 | 2-bit source code per frame bit |
| div | input | DIV_W | Serial half period minus one, in module clocks |
| en_sel | input | 12 | 3-bit phase selection per enable output |
| en_pol | input | 4 | Inactive level per enable output |
| safe_lvl | input | 1 | Data level when idle or stopped |
| estop | input | 1 | Emergency stop |
| sclk_p | output | 1 | Serial clock, true |
| sclk_n | output | 1 | Serial clock, complement |
| sdo_p | output | 1 | Serial data, true |
| sdo_n | output | 1 | Serial data, complement |
| en_out | output | 4 | Mapped enable outputs |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Single-cycle completion pulse |

## Verification
Bit k of the frame appears on the first clock edge after the start edge plus 2k(`div`+1) edges. The rising edge of `sclk_p` follows `div`+1 edges later. `frame_done` appears 64(`div`+1) edges after the start edge, and `busy` falls one edge after that. The bench samples at the falling edge of the module clock after each of these edges and compares the whole output vector, including the enables and the complement pins, with values it computes from the configuration. The effect of emergency stop on the outputs is checked in the same cycle it is raised, and the frame is checked as dropped one edge later.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
    localparam int FRAME_W   = 32;
    localparam int HALF_W    = FRAME_W / 2;
    localparam int NUM_EN    = 4;
    localparam int SRC_W     = 2;
    localparam int ESEL_W    = 3;
    localparam int BITCNT_W  = $clog2(FRAME_W);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_t;

    typedef enum logic [SRC_W-1:0] {
        SRC_DATA = 2'b00,
        SRC_CMD  = 2'b01,
        SRC_ALT  = 2'b10,
        SRC_RSV  = 2'b11
    } src_t;

    localparam logic [ESEL_W-1:0] ESEL_LO  = 3'd0;
    localparam logic [ESEL_W-1:0] ESEL_HI  = 3'd1;
    localparam logic [ESEL_W-1:0] ESEL_CMD = 3'd2;
    localparam logic [ESEL_W-1:0] ESEL_ANY = 3'd3;

    typedef struct packed {
        logic lo;
        logic hi;
        logic cm;
    } phase_t;

    function automatic logic pick_phase(input logic [ESEL_W-1:0] sel, input phase_t ph);
        case (sel)
            ESEL_LO:  return ph.lo;
            ESEL_HI:  return ph.hi;
            ESEL_CMD: return ph.cm;
            ESEL_ANY: return ph.lo | ph.hi;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sdt_loader.sv
module sdt_loader
    import sdt_pkg::*;
(
    input  logic [FRAME_W-1:0]       data_word,
    input  logic [FRAME_W-1:0]       cmd_word,
    input  logic [HALF_W-1:0]        alt_lo,
    input  logic [HALF_W-1:0]        alt_hi,
    input  logic [SRC_W*FRAME_W-1:0] src_sel,
    input  logic                     cmd_frame,
    output logic [FRAME_W-1:0]       load_word
);
    logic [FRAME_W-1:0] alt_word;
    logic [FRAME_W-1:0] mux_word;

    for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
        if (i < HALF_W) begin : g_lo
            assign alt_word[i] = alt_lo[i];
        end else begin : g_hi
            assign alt_word[i] = alt_hi[i-HALF_W];
        end

        src_t code;
        assign code = src_t'(src_sel[SRC_W*i +: SRC_W]);

        always_comb begin
            case (code)
                SRC_CMD: mux_word[i] = cmd_word[i];
                SRC_ALT: mux_word[i] = alt_word[i];
                default: mux_word[i] = data_word[i];
            endcase
        end
    end

    assign load_word = cmd_frame ? cmd_word : mux_word;
endmodule

// File: rtl/sdt_clkdiv.sv
module sdt_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdt_enmap.sv
module sdt_enmap
    import sdt_pkg::*;
(
    input  phase_t                    ph,
    input  logic [ESEL_W*NUM_EN-1:0]  en_sel,
    input  logic [NUM_EN-1:0]         en_pol,
    output logic [NUM_EN-1:0]         en_out
);
    for (genvar i = 0; i < NUM_EN; i++) begin : g_en
        assign en_out[i] = pick_phase(en_sel[ESEL_W*i +: ESEL_W], ph) ^ en_pol[i];
    end
endmodule

// File: rtl/sdt_tx.sv
module sdt_tx
    import sdt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic                             cmd_frame,
    input  logic [sdt_pkg::FRAME_W-1:0]      data_word,
    input  logic [sdt_pkg::FRAME_W-1:0]      cmd_word,
    input  logic [sdt_pkg::HALF_W-1:0]       alt_lo,
    input  logic [sdt_pkg::HALF_W-1:0]       alt_hi,
    input  logic [2*sdt_pkg::FRAME_W-1:0]    src_sel,
    input  logic [DIV_W-1:0]                 div,
    input  logic [3*sdt_pkg::NUM_EN-1:0]     en_sel,
    input  logic [sdt_pkg::NUM_EN-1:0]       en_pol,
    input  logic                             safe_lvl,
    input  logic                             estop,
    output logic                             sclk_p,
    output logic                             sclk_n,
    output logic                             sdo_p,
    output logic                             sdo_n,
    output logic [sdt_pkg::NUM_EN-1:0]       en_out,
    output logic                             busy,
    output logic                             frame_done
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_W - 1);

    st_t                 st;
    logic [FRAME_W-1:0]  sr;
    logic [BITCNT_W-1:0] bitcnt;
    logic                sclk_q;
    logic                is_cmd;
    logic                tick;
    logic                running;
    logic [FRAME_W-1:0]  load_word;
    phase_t              ph;

    assign running = (st == ST_RUN) && !estop;

    sdt_loader u_load (
        .data_word (data_word),
        .cmd_word  (cmd_word),
        .alt_lo    (alt_lo),
        .alt_hi    (alt_hi),
        .src_sel   (src_sel),
        .cmd_frame (cmd_frame),
        .load_word (load_word)
    );

    sdt_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sr     <= '0;
            bitcnt <= '0;
            sclk_q <= 1'b0;
            is_cmd <= 1'b0;
        end else if (estop) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sclk_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st     <= ST_RUN;
                        sr     <= load_word;
                        bitcnt <= '0;
                        sclk_q <= 1'b0;
                        is_cmd <= cmd_frame;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bitcnt == LAST_BIT) begin
                                st <= ST_FIN;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                sr     <= sr >> 1;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ph.lo = running && !is_cmd && !bitcnt[BITCNT_W-1];
    assign ph.hi = running && !is_cmd &&  bitcnt[BITCNT_W-1];
    assign ph.cm = running &&  is_cmd;

    sdt_enmap u_map (
        .ph     (ph),
        .en_sel (en_sel),
        .en_pol (en_pol),
        .en_out (en_out)
    );

    assign sclk_p     = sclk_q && !estop;
    assign sclk_n     = !sclk_p;
    assign sdo_p      = running ? sr[0] : safe_lvl;
    assign sdo_n      = !sdo_p;
    assign busy       = (st != ST_IDLE);
    assign frame_done = (st == ST_FIN);
endmodule

// File: rtl/sdt_tx_chk.sv
module sdt_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       estop,
    input logic       safe_lvl,
    input logic [3:0] en_pol,
    input logic [3:0] en_out,
    input logic       sclk_p,
    input logic       sdo_p,
    input logic       busy,
    input logic       frame_done
);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (en_out == en_pol));

    assert_estop_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        estop |-> (sdo_p == safe_lvl && !sclk_p && en_out == en_pol));

    assert_estop_drop_R8: assert property (@(posedge clk) disable iff (rst)
        estop |=> (!busy && !frame_done));

    assert_idle_clock_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk_p);

    assert_high_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && sclk_p && $past(sclk_p) && !estop && !$past(estop)) |-> $stable(sdo_p));

    assert_start_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !estop) |=> busy);
endmodule

bind sdt_tx sdt_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .estop      (estop),
    .safe_lvl   (safe_lvl),
    .en_pol     (en_pol),
    .en_out     (en_out),
    .sclk_p     (sclk_p),
    .sdo_p      (sdo_p),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/sim_sdt_tx.sv
`timescale 1ns/1ps
module sim_sdt_tx;
    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic        cmd_frame = 0;
    logic [31:0] data_word = 0;
    logic [31:0] cmd_word = 0;
    logic [15:0] alt_lo = 0;
    logic [15:0] alt_hi = 0;
    logic [63:0] src_sel = 0;
    logic [7:0]  div = 0;
    logic [11:0] en_sel = 0;
    logic [3:0]  en_pol = 0;
    logic        safe_lvl = 0;
    logic        estop = 0;
    logic        sclk_p, sclk_n, sdo_p, sdo_n, busy, frame_done;
    logic [3:0]  en_out;

    int total = 0;
    int bad = 0;
    int seed_dummy;

    always #10 clk = ~clk;

    sdt_tx #(.DIV_W(8)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmd_frame(cmd_frame),
        .data_word(data_word), .cmd_word(cmd_word), .alt_lo(alt_lo), .alt_hi(alt_hi),
        .src_sel(src_sel), .div(div), .en_sel(en_sel), .en_pol(en_pol),
        .safe_lvl(safe_lvl), .estop(estop), .sclk_p(sclk_p), .sclk_n(sclk_n),
        .sdo_p(sdo_p), .sdo_n(sdo_n), .en_out(en_out), .busy(busy), .frame_done(frame_done)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w;
        if (cmd_frame) return cmd_word;
        for (int i = 0; i < 32; i++) begin
            case (src_sel[2*i +: 2])
                2'b01:   w[i] = cmd_word[i];
                2'b10:   w[i] = (i < 16) ? alt_lo[i] : alt_hi[i-16];
                default: w[i] = data_word[i];
            endcase
        end
        return w;
    endfunction

    function automatic logic [3:0] en_model(input logic lo, input logic hi, input logic cm);
        logic [3:0] e;
        for (int i = 0; i < 4; i++) begin
            logic a;
            case (en_sel[3*i +: 3])
                3'd0:    a = lo;
                3'd1:    a = hi;
                3'd2:    a = cm;
                3'd3:    a = lo | hi;
                default: a = 1'b0;
            endcase
            e[i] = a ^ en_pol[i];
        end
        return e;
    endfunction

    function automatic logic [9:0] vec(input logic sc, input logic sd, input logic [3:0] en,
                                       input logic b, input logic d);
        return {sc, ~sc, sd, ~sd, en, b, d};
    endfunction

    task automatic check(input string tag, input logic [9:0] exp);
        logic [9:0] act;
        act = {sclk_p, sclk_n, sdo_p, sdo_n, en_out, busy, frame_done};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (sclk sclkn sdo sdon en[3:0] busy done)", tag, act, exp);
        end
    endtask

    task automatic half_wait(input int d);
        repeat (d + 1) @(posedge clk);
        @(negedge clk);
    endtask

    // Runs one frame with the current configuration; poke applies start mid-frame (R9).
    task automatic run_frame(input bit poke);
        logic [31:0] w;
        logic        cm;
        int          d;
        w  = exp_word();
        cm = cmd_frame;
        d  = int'(div);
        @(negedge clk);
        start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 32; k++) begin
            logic [3:0] e;
            e = en_model(!cm && k < 16, !cm && k >= 16, cm);
            check(cm ? "R3 R4 R5 R6 R7 R11 low half-period" : "R2 R4 R5 R6 R7 R11 low half-period",
                  vec(1'b0, w[k], e, 1'b1, 1'b0));
            if (poke && k == 5) begin
                start     = 1;
                cmd_frame = ~cmd_frame;
                data_word = ~data_word;
                cmd_word  = ~cmd_word;
            end
            half_wait(d);
            start = 0;
            check(poke ? "R9 R4 high half-period while restarted" : "R4 R7 high half-period",
                  vec(1'b1, w[k], e, 1'b1, 1'b0));
            half_wait(d);
        end
        check("R10 done pulse with enables inactive", vec(1'b0, safe_lvl, en_pol, 1'b1, 1'b1));
        @(posedge clk);
        @(negedge clk);
        check("R10 R11 back to idle", vec(1'b0, safe_lvl, en_pol, 1'b0, 1'b0));
    endtask

    task automatic randomize_cfg();
        data_word = $urandom;
        cmd_word  = $urandom;
        alt_lo    = 16'($urandom);
        alt_hi    = 16'($urandom);
        src_sel   = {$urandom, $urandom};
        en_sel    = 12'($urandom);
        en_pol    = 4'($urandom);
        safe_lvl  = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd1234);
        en_pol   = 4'b1010;
        safe_lvl = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset state", vec(1'b0, 1'b1, 4'b1010, 1'b0, 1'b0));

        // R2 directed: every source code, including the reserved one, with all four enable maps
        data_word = 32'hA5A5_0F0F; cmd_word = 32'h3C3C_F00F;
        alt_lo = 16'h1234; alt_hi = 16'hFEDC;
        src_sel = 64'hE4E4_E4E4_1B1B_1B1B;
        en_sel = {3'd3, 3'd2, 3'd1, 3'd0}; en_pol = 4'b0100; div = 0; cmd_frame = 0;
        run_frame(0);

        // R3 command frame with slower clock, unused select code 5 on one output
        cmd_frame = 1; div = 2; en_sel = {3'd5, 3'd2, 3'd2, 3'd3}; en_pol = 4'b0001;
        run_frame(0);

        // R2 all alternate bus
        cmd_frame = 0; div = 1; src_sel = {32{2'b10}}; en_sel = {3'd0, 3'd1, 3'd3, 3'd0};
        run_frame(0);

        // R9 start and input changes while busy are ignored
        randomize_cfg(); cmd_frame = 0; div = 1;
        run_frame(1);
        cmd_frame = 0;

        // R8 emergency stop mid-frame
        randomize_cfg(); div = 0;
        @(negedge clk);
        start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        estop = 1;
        #1;
        check("R8 same-cycle safe outputs", vec(1'b0, safe_lvl, en_pol, 1'b1, 1'b0));
        @(negedge clk);
        check("R8 frame dropped", vec(1'b0, safe_lvl, en_pol, 1'b0, 1'b0));
        start = 1;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            check("R9 start blocked by estop", vec(1'b0, safe_lvl, en_pol, 1'b0, 1'b0));
        end
        start = 0;
        estop = 0;
        @(negedge clk);
        check("R8 idle after release", vec(1'b0, safe_lvl, en_pol, 1'b0, 1'b0));

        // random frames
        for (int n = 0; n < 6; n++) begin
            randomize_cfg();
            cmd_frame = 1'($urandom);
            div = 8'($urandom % 3);
            run_frame(0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule